// File: doc/BRIEF.md
# Program Counter Sequencing Unit

This unit keeps the instruction fetch address of a simple 32-bit load/store processor and works out where the next fetch comes from. Each cycle it receives the instruction word currently at the fetch address and the two register operands that the register file has already read for it. On a clock edge where the step enable is high, it moves to the next address. That address is one of four: the next sequential word, a PC-relative conditional branch target, an absolute jump target inside the current 256 MiB region, or a register-held address. For the two linking jumps it also raises a write request toward the register file. The request carries the destination index and the return address.

Every instruction is sorted into one flow class by a single `unique case`. The classes are:
- `FLOW_SEQ`: ordinary advance by one word.
- `FLOW_BR_TAKEN`: a branch whose condition holds.
- `FLOW_BR_SKIP`: a branch whose condition fails, which also advances by one word.
- `FLOW_JABS`: an absolute jump.
- `FLOW_JREG`: a register-indirect jump.
- `FLOW_FAULT`: a register-indirect jump to an address that is not word-aligned.

The only state is the program counter register. Its transitions are:
- reset, which loads `RESET_PC`;
- hold, when the step enable is low or the class is `FLOW_FAULT`;
- load, which takes the address selected by the class.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` equals `RESET_PC` (default 0), and it takes that value without waiting for a clock edge.
- R2: `fetch_addr` changes only on a rising clock edge with `step_en` high. With `step_en` low it holds, and `link_we` stays low.
- R3: An instruction that is not a branch or jump (any opcode in bits [31:26] other than 0x02, 0x03, 0x04, 0x05, and opcode 0 with a funct in bits [5:0] other than 0x08 and 0x09) advances the address by 4.
- R4: Opcode 0x04 branches when `rs_val` equals `rt_val`. Opcode 0x05 branches when they differ. A branch whose condition fails advances by 4.
- R5: A taken branch loads the address plus 4 plus the sign-extended bits [15:0] shifted left by 2.
- R6: Opcodes 0x02 and 0x03 load the top 4 bits of the current address, followed by bits [25:0] of the instruction, followed by two zero bits.
- R7: Opcode 0x03 with `step_en` high raises `link_we` with `link_idx` 31 and `link_data` equal to the current address plus 4.
- R8: Opcode 0 with funct 0x08 loads `rs_val`.
- R9: Opcode 0 with funct 0x09 loads `rs_val`. It also raises `link_we` with `link_idx` equal to bits [15:11] and `link_data` equal to the current address plus 4. The link is suppressed when bits [15:11] are 0. The jump uses the presented `rs_val` even when the link index equals the rs index.
- R10: When funct 0x08 or 0x09 under opcode 0 sees `rs_val[1:0]` nonzero, `misalign` is high in that same cycle, `link_we` is low, and `fetch_addr` holds.
- R11: Bits [1:0] of `fetch_addr` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Allows the address to advance on this edge |
| instr | input | 32 | Instruction word at `fetch_addr` |
| rs_val | input | 32 | Value of the register named in bits [25:21] |
| rt_val | input | 32 | Value of the register named in bits [20:16] |
| fetch_addr | output | 32 | Current program counter |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Register index for the return address |
| link_data | output | 32 | Return address (`fetch_addr` + 4) |
| misalign | output | 1 | Register-indirect target not word-aligned |

## Verification
`misalign`, `link_we`, `link_idx` and `link_data` are combinational in the current instruction, operands and address. They are therefore due in the same cycle the stimulus is applied. The bench drives each vector on a falling edge and samples these outputs 1 ns later, before any rising edge. `fetch_addr` is due one rising edge after the stimulus, so the bench reads it on the following falling edge. Reset is checked asynchronously, 1 ns after `rst_n` falls in the middle of a run.

// File: rtl/pcu_pkg.sv
`timescale 1ns/1ps
package pcu_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BR_TAKEN,
        FLOW_BR_SKIP,
        FLOW_JABS,
        FLOW_JREG,
        FLOW_FAULT
    } flow_e;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_JUMP    = 6'h02;
    localparam logic [5:0] OPC_JLINK   = 6'h03;
    localparam logic [5:0] OPC_BR_EQ   = 6'h04;
    localparam logic [5:0] OPC_BR_NE   = 6'h05;

    localparam logic [5:0] FN_JREG     = 6'h08;
    localparam logic [5:0] FN_JREG_LNK = 6'h09;

endpackage

// File: rtl/pcu_classify.sv
`timescale 1ns/1ps
module pcu_classify
    import pcu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int REG_IDX_W = 5,
    parameter int LINK_REG  = 31
) (
    input  logic [31:0]          instr,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    output flow_e                flow,
    output logic                 link_req,
    output logic [REG_IDX_W-1:0] link_sel
);

    localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

    logic [5:0]           opcode;
    logic [5:0]           funct;
    logic [REG_IDX_W-1:0] rd_idx;
    logic                 operands_eq;
    logic                 rs_unaligned;

    assign opcode       = instr[31:26];
    assign funct        = instr[5:0];
    assign rd_idx       = instr[11 +: REG_IDX_W];
    assign operands_eq  = (rs_val == rt_val);
    assign rs_unaligned = (rs_val[1:0] != 2'b00);

    always_comb begin
        flow     = FLOW_SEQ;
        link_req = 1'b0;
        link_sel = '0;
        unique case (opcode)
            OPC_SPECIAL: begin
                if (funct == FN_JREG || funct == FN_JREG_LNK) begin
                    if (rs_unaligned) begin
                        flow = FLOW_FAULT;
                    end else begin
                        flow = FLOW_JREG;
                        if (funct == FN_JREG_LNK && rd_idx != '0) begin
                            link_req = 1'b1;
                            link_sel = rd_idx;
                        end
                    end
                end
            end
            OPC_BR_EQ: flow = operands_eq ? FLOW_BR_TAKEN : FLOW_BR_SKIP;
            OPC_BR_NE: flow = operands_eq ? FLOW_BR_SKIP : FLOW_BR_TAKEN;
            OPC_JUMP:  flow = FLOW_JABS;
            OPC_JLINK: begin
                flow     = FLOW_JABS;
                link_req = 1'b1;
                link_sel = LINK_IDX;
            end
            default:   flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
`timescale 1ns/1ps
module pcu_target
    import pcu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs_val,
    input  flow_e           flow,
    output logic [XLEN-1:0] seq_pc,
    output logic [XLEN-1:0] next_pc
);

    localparam int OFS_EXT_W = XLEN - 18;
    localparam int REGION_W  = XLEN - 28;

    logic [XLEN-1:0] branch_pc;
    logic [XLEN-1:0] region_pc;

    assign seq_pc    = pc + XLEN'(4);
    assign branch_pc = seq_pc + {{OFS_EXT_W{instr[15]}}, instr[15:0], 2'b00};
    assign region_pc = {pc[XLEN-1 -: REGION_W], instr[25:0], 2'b00};

    always_comb begin
        unique case (flow)
            FLOW_BR_TAKEN: next_pc = branch_pc;
            FLOW_JABS:     next_pc = region_pc;
            FLOW_JREG:     next_pc = rs_val;
            FLOW_FAULT:    next_pc = pc;
            default:       next_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer
    import pcu_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              REG_IDX_W = 5,
    parameter int              LINK_REG  = 31,
    parameter logic [XLEN-1:0] RESET_PC  = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_en,
    input  logic [31:0]          instr,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    output logic [XLEN-1:0]      fetch_addr,
    output logic                 link_we,
    output logic [REG_IDX_W-1:0] link_idx,
    output logic [XLEN-1:0]      link_data,
    output logic                 misalign
);

    flow_e                flow;
    logic                 link_req;
    logic [REG_IDX_W-1:0] link_sel;
    logic [XLEN-1:0]      pc_q;
    logic [XLEN-1:0]      seq_pc;
    logic [XLEN-1:0]      next_pc;

    pcu_classify #(
        .XLEN      (XLEN),
        .REG_IDX_W (REG_IDX_W),
        .LINK_REG  (LINK_REG)
    ) u_classify (
        .instr    (instr),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .flow     (flow),
        .link_req (link_req),
        .link_sel (link_sel)
    );

    pcu_target #(
        .XLEN (XLEN)
    ) u_target (
        .pc      (pc_q),
        .instr   (instr),
        .rs_val  (rs_val),
        .flow    (flow),
        .seq_pc  (seq_pc),
        .next_pc (next_pc)
    );

    // State register: reset, hold or load.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else if (step_en) begin
            pc_q <= next_pc;
        end
    end

    // Output process.
    always_comb begin
        fetch_addr = pc_q;
        misalign   = (flow == FLOW_FAULT);
        link_we    = step_en && link_req;
        link_idx   = link_sel;
        link_data  = seq_pc;
    end

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(fetch_addr));

    assert_no_link_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |-> !link_we);

    assert_seq_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && instr[31:26] == 6'h08) |=> fetch_addr == $past(fetch_addr) + XLEN'(4));

    assert_jal_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && instr[31:26] == OPC_JLINK) |->
            (link_we && link_idx == REG_IDX_W'(LINK_REG) && link_data == fetch_addr + XLEN'(4)));

    assert_link_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_idx != '0);

    assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> $stable(fetch_addr));

    assert_fault_nolink_R10: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> !link_we);

    assert_word_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_addr[1:0] == 2'b00);

endmodule

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

    typedef struct packed {
        logic [31:0] tag;
        logic [31:0] instr;
        logic [31:0] rs;
        logic [31:0] rt;
        logic        step;
        logic [31:0] nxt;
        logic        lwe;
        logic [4:0]  lidx;
        logic [31:0] ldata;
        logic        mis;
    } vec_t;

    localparam int NV = 18;

    // Walked in order from reset (address 0).
    localparam vec_t VECS [NV] = '{
        '{"R3",  32'h00000000, 32'h0,        32'h0, 1'b1, 32'h00000004, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R2",  32'h10220003, 32'h5,        32'h5, 1'b0, 32'h00000004, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R4",  32'h10220003, 32'h5,        32'h5, 1'b1, 32'h00000014, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R4",  32'h10220003, 32'h5,        32'h6, 1'b1, 32'h00000018, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R5",  32'h1422FFFE, 32'h5,        32'h6, 1'b1, 32'h00000014, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R4",  32'h1422FFFE, 32'h7,        32'h7, 1'b1, 32'h00000018, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R6",  32'h08000100, 32'h0,        32'h0, 1'b1, 32'h00000400, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R7",  32'h0C000200, 32'h0,        32'h0, 1'b1, 32'h00000800, 1'b1, 5'd31, 32'h00000404, 1'b0},
        '{"R8",  32'h00200008, 32'h00001000, 32'h0, 1'b1, 32'h00001000, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R9",  32'h00200809, 32'h00002000, 32'h0, 1'b1, 32'h00002000, 1'b1, 5'd1,  32'h00001004, 1'b0},
        '{"R9",  32'h00200009, 32'h00003000, 32'h0, 1'b1, 32'h00003000, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R10", 32'h00200008, 32'h00004002, 32'h0, 1'b1, 32'h00003000, 1'b0, 5'd0,  32'h0,        1'b1},
        '{"R10", 32'h00203809, 32'h00004001, 32'h0, 1'b1, 32'h00003000, 1'b0, 5'd0,  32'h0,        1'b1},
        '{"R2",  32'h0C000200, 32'h0,        32'h0, 1'b0, 32'h00003000, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R8",  32'h00200008, 32'hA0000000, 32'h0, 1'b1, 32'hA0000000, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R6",  32'h0BFFFFFF, 32'h0,        32'h0, 1'b1, 32'hAFFFFFFC, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R5",  32'h10228000, 32'h9,        32'h9, 1'b1, 32'hAFFE0000, 1'b0, 5'd0,  32'h0,        1'b0},
        '{"R3",  32'h2129FFFD, 32'h1,        32'h2, 1'b1, 32'hAFFE0004, 1'b0, 5'd0,  32'h0,        1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] fetch_addr;
    logic        link_we;
    logic [4:0]  link_idx;
    logic [31:0] link_data;
    logic        misalign;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .instr      (instr),
        .rs_val     (rs_val),
        .rt_val     (rt_val),
        .fetch_addr (fetch_addr),
        .link_we    (link_we),
        .link_idx   (link_idx),
        .link_data  (link_data),
        .misalign   (misalign)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: value during reset
        #1;
        chk("R1", "fetch_addr in reset", fetch_addr, 32'h0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            instr   = VECS[i].instr;
            rs_val  = VECS[i].rs;
            rt_val  = VECS[i].rt;
            step_en = VECS[i].step;
            #1;
            chk(string'(VECS[i].tag), "misalign", {31'b0, misalign}, {31'b0, VECS[i].mis});
            chk(string'(VECS[i].tag), "link_we", {31'b0, link_we}, {31'b0, VECS[i].lwe});
            if (VECS[i].lwe) begin
                chk(string'(VECS[i].tag), "link_idx", {27'b0, link_idx}, {27'b0, VECS[i].lidx});
                chk(string'(VECS[i].tag), "link_data", link_data, VECS[i].ldata);
            end
            @(negedge clk);
            chk(string'(VECS[i].tag), "fetch_addr", fetch_addr, VECS[i].nxt);
            chk("R11", "fetch_addr low bits", {30'b0, fetch_addr[1:0]}, 32'h0);
        end

        // R10: fault flag with step low, address still held
        instr   = 32'h00200008;
        rs_val  = 32'h00000003;
        step_en = 1'b0;
        #1;
        chk("R10", "misalign step low", {31'b0, misalign}, 32'h1);
        @(negedge clk);
        chk("R10", "fetch_addr step low", fetch_addr, 32'hAFFE0004);

        // R2: several idle edges with a taken jump presented
        instr = 32'h08000001;
        repeat (3) @(negedge clk);
        chk("R2", "fetch_addr idle edges", fetch_addr, 32'hAFFE0004);

        // R1: asynchronous reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R1", "fetch_addr async reset", fetch_addr, 32'h0);
        @(negedge clk);
        rst_n   = 1'b1;
        instr   = 32'h00000000;
        step_en = 1'b1;
        @(negedge clk);
        chk("R3", "advance after reset", fetch_addr, 32'h00000004);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule